// File: doc/BRIEF.md
# IOM-2 Multi-Channel Word Serializer

This block is the full-duplex serial engine on the controller side of an IOM-2 style telecom bus. It runs on a fast system clock. The bus bit clock and the frame sync arrive as plain inputs, and the block samples both against that clock. Each frame holds between one and eight 32-bit channels. On the transmit line each word is driven most significant bit first. On the receive line a word of the same length is gathered in the matching slot at the same time. No companding is applied in either direction.

Words are exchanged in parallel through valid/ready ports, and each word carries the index of its channel slot. A one-word holding register sits on the transmit side. While it is empty, the block reports which slot the next word will fill. A word offered in the same cycle that a slot starts goes straight onto the line. The receive side keeps one finished word until it is taken. An empty transmit slot sends all ones, and an unread receive word is overwritten. Both events raise a one-cycle flag.

After enable the port stays silent until a frame sync arrives. That first sync wakes it, and from then on it follows every sync. A sync that comes before the current frame has finished cuts that frame short and starts again at slot 0. The bit clock must be slower than half the system clock.

Top module: `iom_serializer`

## Requirements
- R1: After reset, and while enable is low, the transmit line is high, the awake flag is low, transmit ready is low and neither error flag pulses. The channel count is copied from its input while enable is low.
- R2: Once enabled, the awake flag rises only at the first bit-clock rising edge where the frame sync is sampled high after having been low at the previous rising edge. Later syncs leave it high.
- R3: Data delay is zero. In the cycle after the bit-clock rise that takes the sync, the transmit line carries bit 31 of the slot-0 word. After each later bit-clock rise it carries the next lower bit, MSB first.
- R4: A frame carries N = count+1 words, with N from 1 to 8, using the value latched when enable went high. After the last bit of slot N-1 the line returns high until the next sync. Changing the count input while enabled has no effect.
- R5: Receive bits are sampled on bit-clock falling edges, MSB first. After the falling edge of the 32nd bit of a slot, the word appears on the receive data port with that slot's index and receive valid high.
- R6: Transmit ready equals enable AND an empty holding register. The transmit slot output names the slot the next word will fill: 0 outside a frame and after the last slot, otherwise the current slot plus one. A word accepted in the cycle a slot starts is sent in that slot.
- R7: When a slot starts with no word held and none offered, the slot sends 32 ones and the underrun flag pulses for exactly one cycle.
- R8: When a word finishes while the previous word is still valid and not being taken, the new word replaces it and the overrun flag pulses for one cycle.
- R9: Receive valid, data and slot stay unchanged until receive ready is high, except when an overrun replaces them.
- R10: A sync that arrives inside a frame restarts at slot 0, bit 31. The receive bits gathered for the cut-short word are thrown away.
- R11: Dropping enable clears the awake flag and empties the transmit holding register. After enable rises again, nothing is sent until a new sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Port enable; low holds idle and latches channel count |
| slots_m1_i | input | 3 | Channel count minus one |
| bclk_i | input | 1 | Bus bit clock |
| fsync_i | input | 1 | Bus frame sync, active high |
| din_i | input | 1 | Serial receive data |
| dout_o | output | 1 | Serial transmit data, idle high |
| tx_data_i | input | 32 | Transmit word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register can take a word |
| tx_slot_o | output | 3 | Slot the next accepted word fills |
| rx_data_o | output | 32 | Received word |
| rx_slot_o | output | 3 | Slot of received word |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Consumer takes received word |
| awake_o | output | 1 | Port woken by first sync |
| underrun_o | output | 1 | One-cycle pulse: slot sent all ones |
| overrun_o | output | 1 | One-cycle pulse: unread word replaced |

## Verification
Two pairs of events can land in the same clock cycle, and the bench forces both. The first pair is a transmit handshake together with a slot start. The bench keeps its transmit queue sparse, so a word is sometimes offered in exactly the cycle the slot opens; that word must go onto the line with no underrun. The second pair is the last receive sample together with receive ready. The bench toggles ready at random around word ends; a word taken in the completion cycle must not count as an overrun, while a word left untaken must. A behavioural model advances on every clock and judges both cases by comparing every output each cycle.

// File: rtl/iom_pkg.sv
// Shared types for the IOM-2 word serializer.
package iom_pkg;

    // Action requested of the transmit path at a bit-clock rising edge.
    typedef enum logic [1:0] {
        EV_NONE,
        EV_LOAD,
        EV_SHIFT,
        EV_STOP
    } tx_event_e;

endpackage

// File: rtl/iom_frame_timer.sv
// Frame timer: finds bit-clock edges and frame-sync rising edges,
// keeps the bit and slot counters, and decides each rise whether the
// transmit path loads, shifts or goes idle.
// Assumes bit clock period is at least four system clocks.
module iom_frame_timer
    import iom_pkg::*;
#(
    parameter  int WORD_W    = 32,
    parameter  int MAX_SLOTS = 8,
    localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int BIT_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [SLOT_W-1:0] slots_m1_i,
    input  logic              bclk_i,
    input  logic              fsync_i,
    output tx_event_e         tx_ev_o,
    output logic              rx_strobe_o,
    output logic              last_bit_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [SLOT_W-1:0] next_slot_o,
    output logic              awake_o
);

    logic              bclk_q;
    logic              fs_prev;
    logic              active_q;
    logic              awake_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] n_lat;
    logic [BIT_W-1:0]  bit_q;
    logic              rise;
    logic              fall;
    logic              sync_edge;
    logic              last_slot;

    assign rise      = bclk_i & ~bclk_q;
    assign fall      = ~bclk_i & bclk_q;
    assign sync_edge = enable_i & rise & fsync_i & ~fs_prev;
    assign last_bit_o = (bit_q == BIT_W'(WORD_W - 1));
    assign last_slot = (slot_q == n_lat);

    assign rx_strobe_o = enable_i & fall & active_q;
    assign slot_o      = slot_q;
    assign next_slot_o = (active_q && !last_slot) ? slot_q + 1'b1 : '0;
    assign awake_o     = awake_q;

    // Pick the transmit action for this cycle.
    always_comb begin
        tx_ev_o = EV_NONE;
        if (sync_edge) begin
            tx_ev_o = EV_LOAD;
        end else if (enable_i && rise && active_q) begin
            if (last_bit_o) begin
                tx_ev_o = last_slot ? EV_STOP : EV_LOAD;
            end else begin
                tx_ev_o = EV_SHIFT;
            end
        end
    end

    // Track bit-clock level and frame sync level at each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            if (rise) begin
                fs_prev <= fsync_i;
            end
        end
    end

    // Advance bit and slot counters, wake-up and channel-count latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            awake_q  <= 1'b0;
            slot_q   <= '0;
            bit_q    <= '0;
            n_lat    <= '0;
        end else if (!enable_i) begin
            active_q <= 1'b0;
            awake_q  <= 1'b0;
            n_lat    <= slots_m1_i;
        end else if (sync_edge) begin
            active_q <= 1'b1;
            awake_q  <= 1'b1;
            slot_q   <= '0;
            bit_q    <= '0;
        end else if (rise && active_q) begin
            if (last_bit_o) begin
                bit_q <= '0;
                if (last_slot) begin
                    active_q <= 1'b0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iom_tx_path.sv
// Transmit path: one-word holding register behind a valid/ready port
// and an MSB-first shift register that drives the serial line.
// Assumes tx_ev_o events are at least two clocks apart.
module iom_tx_path
    import iom_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  tx_event_e         tx_ev_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              dout_o,
    output logic              underrun_o
);

    logic [WORD_W-1:0] hold_q;
    logic              hold_v;
    logic [WORD_W-1:0] sh_q;
    logic              dout_q;
    logic              under_q;
    logic              take;
    logic              fill;
    logic [WORD_W-1:0] load_word;

    assign tx_ready_o = enable_i & ~hold_v;
    assign take       = tx_valid_i & tx_ready_o;
    assign dout_o     = dout_q;
    assign underrun_o = under_q;

    // Choose the word for a slot start: held, offered now, or all ones.
    always_comb begin
        fill = 1'b0;
        if (hold_v) begin
            load_word = hold_q;
        end else if (take) begin
            load_word = tx_data_i;
        end else begin
            load_word = '1;
            fill      = 1'b1;
        end
    end

    // Update holding register, shift register, line and underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            hold_v  <= 1'b0;
            sh_q    <= '1;
            dout_q  <= 1'b1;
            under_q <= 1'b0;
        end else begin
            under_q <= 1'b0;
            if (!enable_i) begin
                hold_v <= 1'b0;
                dout_q <= 1'b1;
            end else if (tx_ev_i == EV_LOAD) begin
                dout_q  <= load_word[WORD_W-1];
                sh_q    <= {load_word[WORD_W-2:0], 1'b1};
                hold_v  <= 1'b0;
                under_q <= fill;
            end else begin
                if (take) begin
                    hold_q <= tx_data_i;
                    hold_v <= 1'b1;
                end
                if (tx_ev_i == EV_SHIFT) begin
                    dout_q <= sh_q[WORD_W-1];
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b1};
                end else if (tx_ev_i == EV_STOP) begin
                    dout_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/iom_rx_path.sv
// Receive path: gathers serial bits MSB first on each strobe and
// presents finished words with their slot index on a valid/ready port.
// Assumes the strobe marks bit-clock falling edges inside a frame.
module iom_rx_path #(
    parameter int WORD_W = 32,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe_i,
    input  logic              last_bit_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              din_i,
    input  logic              rx_ready_i,
    output logic [WORD_W-1:0] rx_data_o,
    output logic [SLOT_W-1:0] rx_slot_o,
    output logic              rx_valid_o,
    output logic              overrun_o
);

    logic [WORD_W-2:0] sh_q;
    logic [WORD_W-1:0] data_q;
    logic [SLOT_W-1:0] slot_q;
    logic              valid_q;
    logic              over_q;

    assign rx_data_o  = data_q;
    assign rx_slot_o  = slot_q;
    assign rx_valid_o = valid_q;
    assign overrun_o  = over_q;

    // Shift in bits, publish finished words, handle handshake and overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            data_q  <= '0;
            slot_q  <= '0;
            valid_q <= 1'b0;
            over_q  <= 1'b0;
        end else begin
            over_q <= 1'b0;
            if (rx_strobe_i) begin
                sh_q <= {sh_q[WORD_W-3:0], din_i};
            end
            if (rx_strobe_i && last_bit_i) begin
                data_q  <= {sh_q, din_i};
                slot_q  <= slot_i;
                valid_q <= 1'b1;
                over_q  <= valid_q & ~rx_ready_i;
            end else if (valid_q && rx_ready_i) begin
                valid_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iom_serializer.sv
// IOM-2 word serializer top: joins the frame timer with the transmit
// and receive paths. Bit clock and frame sync are sampled on clk and
// are assumed to be already synchronous to it.
module iom_serializer
    import iom_pkg::*;
#(
    parameter  int WORD_W    = 32,
    parameter  int MAX_SLOTS = 8,
    localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [SLOT_W-1:0] slots_m1_i,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              din_i,
    output logic              dout_o,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [SLOT_W-1:0] tx_slot_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic [SLOT_W-1:0] rx_slot_o,
    output logic              rx_valid_o,
    input  logic              rx_ready_i,
    output logic              awake_o,
    output logic              underrun_o,
    output logic              overrun_o
);

    tx_event_e         tx_ev;
    logic              rx_strobe;
    logic              last_bit;
    logic [SLOT_W-1:0] cur_slot;

    iom_frame_timer #(
        .WORD_W   (WORD_W),
        .MAX_SLOTS(MAX_SLOTS)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .slots_m1_i (slots_m1_i),
        .bclk_i     (bclk_i),
        .fsync_i    (fsync_i),
        .tx_ev_o    (tx_ev),
        .rx_strobe_o(rx_strobe),
        .last_bit_o (last_bit),
        .slot_o     (cur_slot),
        .next_slot_o(tx_slot_o),
        .awake_o    (awake_o)
    );

    iom_tx_path #(
        .WORD_W(WORD_W)
    ) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .tx_ev_i   (tx_ev),
        .tx_data_i (tx_data_i),
        .tx_valid_i(tx_valid_i),
        .tx_ready_o(tx_ready_o),
        .dout_o    (dout_o),
        .underrun_o(underrun_o)
    );

    iom_rx_path #(
        .WORD_W(WORD_W),
        .SLOT_W(SLOT_W)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_strobe_i(rx_strobe),
        .last_bit_i (last_bit),
        .slot_i     (cur_slot),
        .din_i      (din_i),
        .rx_ready_i (rx_ready_i),
        .rx_data_o  (rx_data_o),
        .rx_slot_o  (rx_slot_o),
        .rx_valid_o (rx_valid_o),
        .overrun_o  (overrun_o)
    );

endmodule

// File: rtl/iom_serializer_chk.sv
// Port-level protocol checks for iom_serializer, attached by bind.
module iom_serializer_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              bclk_i,
    input logic              fsync_i,
    input logic              dout_o,
    input logic              tx_ready_o,
    input logic [WORD_W-1:0] rx_data_o,
    input logic              rx_valid_o,
    input logic              rx_ready_i,
    input logic              awake_o,
    input logic              underrun_o,
    input logic              overrun_o
);

    logic bclk_d;
    logic bclk_rise;

    assign bclk_rise = bclk_i & ~bclk_d;

    // Remember the previous bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_i;
    end

    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (dout_o && !awake_o));

    assert_wake_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake_o) |-> $past(fsync_i));

    assert_line_moves_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_o != $past(dout_o)) |-> ($past(bclk_rise) || $past(!enable_i) || $past(!rst_n)));

    assert_no_ready_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !tx_ready_o);

    assert_underrun_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);

    assert_overrun_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> !overrun_o);

    assert_overrun_keeps_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> rx_valid_o);

    assert_rx_valid_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !rx_ready_i) |=> rx_valid_o);

    assert_rx_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !rx_ready_i) |=> ($stable(rx_data_o) || overrun_o));

endmodule

bind iom_serializer iom_serializer_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .bclk_i    (bclk_i),
    .fsync_i   (fsync_i),
    .dout_o    (dout_o),
    .tx_ready_o(tx_ready_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i),
    .awake_o   (awake_o),
    .underrun_o(underrun_o),
    .overrun_o (overrun_o)
);

// File: tb/iom_serializer_tb_top.sv
`timescale 1ns/1ps
// Bench for iom_serializer: drives a bus bit clock of four system
// clocks, runs a behavioural model on every edge, compares all outputs.
module iom_serializer_tb_top;

    localparam int W  = 32;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [SW-1:0] slots_m1 = 3'd2;
    logic          bclk = 1'b0;
    logic          fsync = 1'b0;
    logic          din = 1'b1;
    logic          dout;
    logic [W-1:0]  tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [SW-1:0] tx_slot;
    logic [W-1:0]  rx_data;
    logic [SW-1:0] rx_slot;
    logic          rx_valid;
    logic          rx_ready = 1'b1;
    logic          awake;
    logic          underrun;
    logic          overrun;

    always #2 clk = ~clk;

    iom_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .slots_m1_i(slots_m1),
        .bclk_i(bclk), .fsync_i(fsync), .din_i(din), .dout_o(dout),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .tx_slot_o(tx_slot), .rx_data_o(rx_data), .rx_slot_o(rx_slot),
        .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .awake_o(awake),
        .underrun_o(underrun), .overrun_o(overrun)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- stimulus drivers ----------------
    logic [W-1:0] tx_q[$];
    int  ph = 3;
    bit  sync_req = 1'b0;
    int  rx_mode = 0;   // 0 always ready, 1 never, 2 random

    // Bit clock, frame sync, receive line, transmit offer, receive ready.
    always @(negedge clk) begin
        ph = (ph + 1) % 4;
        if (ph == 0) begin
            bclk  = 1'b1;
            fsync = sync_req;
            sync_req = 1'b0;
            din = 1'($urandom);
        end else if (ph == 2) begin
            bclk = 1'b0;
        end
        tx_valid = (tx_q.size() > 0);
        tx_data  = (tx_q.size() > 0) ? tx_q[0] : '0;
        rx_ready = (rx_mode == 0) ? 1'b1 : (rx_mode == 1) ? 1'b0 : ($urandom_range(0, 2) == 0);
    end

    // ---------------- reference model ----------------
    bit           m_bq, m_fsp, m_act, m_bufv;
    int           m_slot, m_bit, m_n;
    logic [W-1:0] m_sh, m_buf, m_rx, w;
    bit           e_dout, e_awake, e_under, e_over, e_rxv;
    logic [W-1:0] e_rxd;
    int           e_rxs;

    // Advance expected state on every system clock edge.
    always @(posedge clk) begin
        bit rise, fall, acc, ld, stp, shf;
        if (!rst_n) begin
            m_bq = 0; m_fsp = 0; m_act = 0; m_bufv = 0; m_slot = 0; m_bit = 0; m_n = 0;
            m_sh = '1; m_buf = '0; m_rx = '0;
            e_dout = 1; e_awake = 0; e_under = 0; e_over = 0; e_rxv = 0; e_rxd = '0; e_rxs = 0;
        end else begin
            rise = bclk && !m_bq;
            fall = !bclk && m_bq;
            acc  = tx_valid && enable && !m_bufv;
            e_under = 0;
            e_over  = 0;
            ld = 0; stp = 0; shf = 0;
            if (!enable) begin
                m_act = 0; e_awake = 0; m_n = int'(slots_m1); e_dout = 1; m_bufv = 0;
            end else begin
                if (rise && fsync && !m_fsp) begin
                    ld = 1; m_act = 1; m_slot = 0; m_bit = 0; e_awake = 1;
                end else if (rise && m_act) begin
                    if (m_bit == W - 1) begin
                        m_bit = 0;
                        if (m_slot == m_n) begin stp = 1; m_act = 0; end
                        else begin ld = 1; m_slot++; end
                    end else begin
                        shf = 1; m_bit++;
                    end
                end
                if (ld) begin
                    if (m_bufv) w = m_buf;
                    else if (acc) begin w = tx_data; void'(tx_q.pop_front()); end
                    else begin w = '1; e_under = 1; end
                    m_bufv = 0;
                    e_dout = w[W-1];
                    m_sh = {w[W-2:0], 1'b1};
                end else begin
                    if (acc) begin m_buf = tx_data; m_bufv = 1; void'(tx_q.pop_front()); end
                    if (shf) begin e_dout = m_sh[W-1]; m_sh = {m_sh[W-2:0], 1'b1}; end
                    else if (stp) e_dout = 1;
                end
            end
            if (enable && fall && m_act) begin
                m_rx = {m_rx[W-2:0], din};
                if (m_bit == W - 1) begin
                    e_over = e_rxv && !rx_ready;
                    e_rxd = m_rx; e_rxs = m_slot; e_rxv = 1;
                end else if (e_rxv && rx_ready) e_rxv = 0;
            end else if (e_rxv && rx_ready) e_rxv = 0;
            if (rise) m_fsp = fsync;
            m_bq = bclk;
        end
    end

    // Compare every output after each edge; tally flags for scenario checks.
    int under_cnt = 0;
    int over_cnt = 0;
    int last_rx_slot = -1;
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R3 dout", 32'(dout), 32'(e_dout));
            chk("R2 awake", 32'(awake), 32'(e_awake));
            chk("R6 tx_ready", 32'(tx_ready), 32'(enable && !m_bufv));
            chk("R6 tx_slot", 32'(tx_slot), 32'(m_act ? ((m_slot == m_n) ? 0 : m_slot + 1) : 0));
            chk("R7 underrun", 32'(underrun), 32'(e_under));
            chk("R8 overrun", 32'(overrun), 32'(e_over));
            chk("R9 rx_valid", 32'(rx_valid), 32'(e_rxv));
            chk("R5 rx_data", rx_data, e_rxd);
            chk("R5 rx_slot", 32'(rx_slot), 32'(e_rxs));
            if (underrun) under_cnt++;
            if (overrun) over_cnt++;
            if (rx_valid) last_rx_slot = int'(rx_slot);
        end
    end

    task automatic wait_periods(input int k);
        repeat (k * 4) @(negedge clk);
    endtask

    task automatic send_sync();
        @(negedge clk);
        sync_req = 1'b1;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        under_cnt = 0;
        over_cnt = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    // Scenario sequence.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle state out of reset while disabled
        chk("R1 dout idle", 32'(dout), 32'd1);
        chk("R1 awake low", 32'(awake), 32'd0);
        chk("R1 tx_ready low", 32'(tx_ready), 32'd0);
        chk("R1 rx_valid low", 32'(rx_valid), 32'd0);

        // R2: enabled but no sync yet
        enable = 1'b1;
        wait_periods(10);
        chk("R2 asleep before sync", 32'(awake), 32'd0);

        // R6: three words supplied, no underrun in a three-slot frame
        tx_q.push_back(32'hA5C3_0F01);
        tx_q.push_back(32'h8000_0001);
        tx_q.push_back(32'h1234_5678);
        clear_counts();
        send_sync();
        wait_periods(3 * 32 + 4);
        chk("R6 no underrun with data", 32'(under_cnt), 32'd0);
        chk("R2 awake after sync", 32'(awake), 32'd1);

        // R7 / R4: empty queue gives one underrun per slot
        clear_counts();
        send_sync();
        wait_periods(3 * 32 + 4);
        chk("R7 underrun per slot", 32'(under_cnt), 32'd3);

        // R8 / R9: receiver never ready
        rx_mode = 1;
        clear_counts();
        send_sync();
        wait_periods(3 * 32 + 4);
        chk("R8 overrun count", 32'(over_cnt), 32'd2);
        chk("R9 word still held", 32'(rx_valid), 32'd1);
        chk("R9 last slot held", 32'(rx_slot), 32'd2);
        rx_mode = 0;
        wait_periods(2);

        // Random ready and sparse transmit offers
        rx_mode = 2;
        for (int f = 0; f < 3; f++) begin
            send_sync();
            for (int s = 0; s < 3; s++) begin
                wait_periods(20 + s);
                tx_q.push_back($urandom);
            end
            wait_periods(3 * 32 - 60);
        end
        rx_mode = 0;
        wait_periods(40);

        // R10: second sync inside slot 1 restarts at slot 0
        tx_q.push_back(32'hFFFF_0000);
        tx_q.push_back(32'h0000_FFFF);
        tx_q.push_back(32'hC0DE_CAFE);
        tx_q.push_back(32'h0F0F_F0F0);
        send_sync();
        wait_periods(40);
        send_sync();
        wait_periods(40);
        chk("R10 restarted at slot 0", 32'(last_rx_slot), 32'd0);
        wait_periods(3 * 32);

        // R11: disable, change count, re-enable without sync
        @(negedge clk);
        enable = 1'b0;
        tx_q.delete();
        wait_periods(2);
        chk("R11 awake cleared", 32'(awake), 32'd0);
        slots_m1 = 3'd7;
        @(negedge clk);
        enable = 1'b1;
        clear_counts();
        wait_periods(20);
        chk("R11 silent until sync", 32'(awake), 32'd0);
        chk("R11 no slots before sync", 32'(under_cnt), 32'd0);

        // R4: eight-slot frame; count input changed mid-frame is ignored
        clear_counts();
        send_sync();
        wait_periods(50);
        slots_m1 = 3'd0;
        wait_periods(8 * 32 - 40);
        chk("R4 eight slots", 32'(under_cnt), 32'd8);

        // R4: single-slot frame after re-latch
        @(negedge clk);
        enable = 1'b0;
        wait_periods(2);
        @(negedge clk);
        enable = 1'b1;
        clear_counts();
        send_sync();
        wait_periods(40);
        chk("R4 one slot", 32'(under_cnt), 32'd1);
        chk("R4 line idle after frame", 32'(dout), 32'd1);

        finish_run();
    end

endmodule